// File: doc/BRIEF.md
# Complex I/Q Waveform Source

This block is a streaming source of complex samples. Each sample is a 16-bit signed in-phase part and a 16-bit signed quadrature part, packed into one 32-bit word. Three waveforms are available: a fixed complex value, a tone made by rotating a programmable starting phasor by a growing angle, and pseudo-random noise taken from a linear feedback shift register. Every waveform passes through the same signed Q1.15 gain multiplier before it reaches the output.

Software sets the block up through a write-only bank of seven registers selected by a 3-bit offset. The tone is produced by an iterative shift-and-add rotator. Because the rotator scales its result by about 1.1644, software divides the starting phasor by that factor in advance. Samples leave on a valid/ready stream, and an end-of-packet flag marks every N-th sample, where N is programmable.

Top module: `cplx_wavegen`

## Requirements
- R1: After reset the source is disabled with m_valid low. It selects the fixed-value waveform with a fixed value of 0, a gain of 0x7FFF, a packet length of 16, an angle accumulator of 0 and a noise register of 1. When enabled from reset with no other writes, it emits the word 0x00000000 without the end flag.
- R2: A write at offset 0 sets enable from bit 0. Offset 1 sets the packet length. Offset 2 sets the waveform code. Offset 3 sets the gain. Offset 4 sets the fixed value. Offset 5 sets the angle step. Offset 6 sets the starting phasor. A write at offset 7 changes nothing and raises cfg_err for exactly the one cycle that follows the write.
- R3: The waveform code in bits 1:0 means 0 = fixed value, 1 = tone, 2 = noise. A write of code 3 is ignored and the previous waveform stays selected.
- R4: In fixed-value mode every sample equals the offset-4 register scaled by the gain. I comes from bits 31:16 and Q from bits 15:0, and the output word keeps the same layout.
- R5: Each component is scaled as floor((v*g + 16384) / 32768) with signed v and g, then saturated to the range -32768..32767.
- R6: In tone mode, sample k after a start is the phasor (I in bits 31:16, Q in bits 15:0) rotated counter-clockwise by k times the angle step, then scaled by the gain. The angle unit is pi/8192. Within 64 LSB, the magnitude equals 1.1644 times the phasor magnitude.
- R7: Writing the phasor clears the angle accumulator. The first tone sample after re-enabling is therefore the new phasor at angle zero.
- R8: In noise mode, I is bits 31:16 and Q is bits 15:0 of a 32-bit register, each scaled by the gain. After each accepted noise sample the register shifts left, taking in bit31^bit21^bit1^bit0 at bit 0.
- R9: While disabled, m_valid is low. A write of enable = 0 drops m_valid from the next cycle.
- R10: While m_valid is high and m_ready low, m_valid, m_data and m_last hold. Angle, noise register and sample counter advance only on an accepted sample.
- R11: m_last is high on sample number N-1 of each packet, counting from 0, and the count then wraps. A packet length of 0 behaves as 1.
- R12: Enabling the source after it was disabled starts a fresh packet with the sample count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_err | output | 1 | One-cycle flag after a write at an undefined offset |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream accepts the sample |
| m_data | output | 32 | Sample, I in 31:16 and Q in 15:0 |
| m_last | output | 1 | Last sample of the packet |

## Verification
The properties take for granted that configuration writes arrive only after the internal reset release and that m_ready is a plain level from the consumer, never depending on m_valid within the same cycle. The stall property assumes that no enable write of zero lands while a sample is held. The stimulus therefore changes waveform, gain, value and phasor only while the source is disabled, leaves two spare cycles after reset, and drives m_ready away from the clock edge. It raises m_ready only once a valid sample has been seen.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  localparam int SAMP_W = 16;
  localparam int ANG_W  = 14;   // 2*pi == 2**ANG_W

  typedef enum logic [1:0] {
    WV_FLAT = 2'd0,
    WV_TONE = 2'd1,
    WV_RAND = 2'd2
  } wave_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_CALC = 2'd1,
    ST_HOLD = 2'd2
  } gen_st_e;

  localparam logic [2:0] OFS_EN     = 3'd0;
  localparam logic [2:0] OFS_SPP    = 3'd1;
  localparam logic [2:0] OFS_WAVE   = 3'd2;
  localparam logic [2:0] OFS_GAIN   = 3'd3;
  localparam logic [2:0] OFS_CONST  = 3'd4;
  localparam logic [2:0] OFS_STEP   = 3'd5;
  localparam logic [2:0] OFS_PHASOR = 3'd6;

  // arctan(2**-i) in units of pi/8192
  function automatic logic [ANG_W-1:0] atan_lut(input logic [3:0] idx);
    logic [ANG_W-1:0] a;
    case (idx)
      4'd1:    a = 14'd1209;
      4'd2:    a = 14'd639;
      4'd3:    a = 14'd324;
      4'd4:    a = 14'd163;
      4'd5:    a = 14'd81;
      4'd6:    a = 14'd41;
      4'd7:    a = 14'd20;
      4'd8:    a = 14'd10;
      4'd9:    a = 14'd5;
      4'd10:   a = 14'd3;
      4'd11:   a = 14'd1;
      4'd12:   a = 14'd1;
      default: a = 14'd0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/cwg_regs.sv
module cwg_regs
  import cwg_pkg::*;
#(
  parameter int               SPP_W   = 16,
  parameter logic [SPP_W-1:0] SPP_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic              en,
  output wave_e             wave,
  output logic [15:0]       gain,
  output logic [31:0]       cval,
  output logic [ANG_W-1:0]  step,
  output logic [31:0]       phasor,
  output logic [SPP_W-1:0]  spp,
  output logic              phasor_wr,
  output logic              bad
);
  logic             en_d, bad_d;
  wave_e            wave_d;
  logic [15:0]      gain_d;
  logic [31:0]      cval_d, phasor_d;
  logic [ANG_W-1:0] step_d;
  logic [SPP_W-1:0] spp_d;

  assign phasor_wr = we && (addr == OFS_PHASOR);

  always_comb begin
    en_d     = en;
    wave_d   = wave;
    gain_d   = gain;
    cval_d   = cval;
    step_d   = step;
    phasor_d = phasor;
    spp_d    = spp;
    bad_d    = we && (addr == 3'd7);
    if (we) begin
      case (addr)
        OFS_EN:     en_d     = wdata[0];
        OFS_SPP:    spp_d    = wdata[SPP_W-1:0];
        OFS_WAVE:   if (wdata[1:0] != 2'd3) wave_d = wave_e'(wdata[1:0]);
        OFS_GAIN:   gain_d   = wdata[15:0];
        OFS_CONST:  cval_d   = wdata;
        OFS_STEP:   step_d   = wdata[ANG_W-1:0];
        OFS_PHASOR: phasor_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      wave   <= WV_FLAT;
      gain   <= 16'h7FFF;
      cval   <= '0;
      step   <= '0;
      phasor <= '0;
      spp    <= SPP_RST;
      bad    <= 1'b0;
    end else begin
      en     <= en_d;
      wave   <= wave_d;
      gain   <= gain_d;
      cval   <= cval_d;
      step   <= step_d;
      phasor <= phasor_d;
      spp    <= spp_d;
      bad    <= bad_d;
    end
  end
endmodule

// File: rtl/cwg_cordic.sv
module cwg_cordic
  import cwg_pkg::*;
#(
  parameter int ITER = 12,
  parameter int XW   = SAMP_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [SAMP_W-1:0] x_in,
  input  logic signed [SAMP_W-1:0] y_in,
  input  logic [ANG_W-1:0]        ang,
  output logic                    busy,
  output logic signed [XW-1:0]    x_out,
  output logic signed [XW-1:0]    y_out
);
  localparam int CW = $clog2(ITER + 1);

  logic signed [XW-1:0]    x_q, y_q, x_d, y_d, xs, ys, x0, y0, xsh, ysh;
  logic signed [ANG_W-1:0] z_q, z_d, res;
  logic [ANG_W-1:0]        t;
  logic [CW-1:0]           it_q, it_d;
  logic                    busy_d;

  // fold the angle into +-pi/4 around one of four quarter turns
  always_comb begin
    t   = ang + ANG_W'(2048);
    res = $signed({2'b00, t[11:0]}) - 14'sd2048;
    xs  = XW'(x_in);
    ys  = XW'(y_in);
    case (t[13:12])
      2'd0:    begin x0 = xs;  y0 = ys;  end
      2'd1:    begin x0 = -ys; y0 = xs;  end
      2'd2:    begin x0 = -xs; y0 = -ys; end
      default: begin x0 = ys;  y0 = -xs; end
    endcase
  end

  always_comb begin
    xsh    = x_q >>> it_q;
    ysh    = y_q >>> it_q;
    x_d    = x_q;
    y_d    = y_q;
    z_d    = z_q;
    it_d   = it_q;
    busy_d = busy;
    if (start) begin
      x_d    = x0;
      y_d    = y0;
      z_d    = res;
      it_d   = CW'(1);
      busy_d = 1'b1;
    end else if (busy) begin
      if (!z_q[ANG_W-1]) begin
        x_d = x_q - ysh;
        y_d = y_q + xsh;
        z_d = z_q - $signed(atan_lut(4'(it_q)));
      end else begin
        x_d = x_q + ysh;
        y_d = y_q - xsh;
        z_d = z_q + $signed(atan_lut(4'(it_q)));
      end
      it_d = it_q + CW'(1);
      if (it_q == CW'(ITER)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      z_q  <= '0;
      it_q <= '0;
      busy <= 1'b0;
    end else begin
      x_q  <= x_d;
      y_q  <= y_d;
      z_q  <= z_d;
      it_q <= it_d;
      busy <= busy_d;
    end
  end

  assign x_out = x_q;
  assign y_out = y_q;
endmodule

// File: rtl/cwg_scale.sv
module cwg_scale #(
  parameter int IN_W = 18
) (
  input  logic signed [IN_W-1:0] v,
  input  logic signed [15:0]     g,
  output logic signed [15:0]     y
);
  localparam int PW = IN_W + 16;
  localparam logic signed [PW-1:0] MAXV = PW'(32767);
  localparam logic signed [PW-1:0] MINV = -PW'(32768);

  logic signed [PW-1:0] prod, sh;

  always_comb begin
    prod = PW'(v) * PW'(g);
    sh   = (prod + PW'(16384)) >>> 15;
    if (sh > MAXV)      y = 16'sh7FFF;
    else if (sh < MINV) y = 16'sh8000;
    else                y = sh[15:0];
  end
endmodule

// File: rtl/cplx_wavegen.sv
module cplx_wavegen
  import cwg_pkg::*;
#(
  parameter int               SPP_W   = 16,
  parameter logic [SPP_W-1:0] SPP_RST = 16,
  parameter int               ITER    = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        cfg_err,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [31:0] m_data,
  output logic        m_last
);
  localparam int XW = SAMP_W + 2;
  localparam int NW = 32;

  logic [1:0]       rs_q;
  logic             rst_ni;
  logic             en, phasor_wr;
  wave_e            wave;
  logic [15:0]      gain;
  logic [31:0]      cval, phasor;
  logic [ANG_W-1:0] step, phase_q, phase_d;
  logic [SPP_W-1:0] spp, spp_eff, cnt_q, cnt_d;
  logic [NW-1:0]    lfsr_q, lfsr_d;
  logic [31:0]      smp_q, smp_d;
  gen_st_e          st_q, st_d;
  logic             accept, start, cap, is_last, cbusy;
  logic signed [XW-1:0]     cx, cy;
  logic signed [XW-1:0]     src [2];
  logic signed [SAMP_W-1:0] scaled [2];

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  cwg_regs #(.SPP_W(SPP_W), .SPP_RST(SPP_RST)) u_regs (
    .clk(clk), .rst_n(rst_ni), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en(en), .wave(wave), .gain(gain), .cval(cval), .step(step),
    .phasor(phasor), .spp(spp), .phasor_wr(phasor_wr), .bad(cfg_err)
  );

  cwg_cordic #(.ITER(ITER), .XW(XW)) u_rot (
    .clk(clk), .rst_n(rst_ni), .start(start),
    .x_in(phasor[31:16]), .y_in(phasor[15:0]), .ang(phase_d),
    .busy(cbusy), .x_out(cx), .y_out(cy)
  );

  always_comb begin
    case (wave)
      WV_TONE: begin src[0] = cx; src[1] = cy; end
      WV_RAND: begin
        src[0] = XW'($signed(lfsr_q[31:16]));
        src[1] = XW'($signed(lfsr_q[15:0]));
      end
      default: begin
        src[0] = XW'($signed(cval[31:16]));
        src[1] = XW'($signed(cval[15:0]));
      end
    endcase
  end

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    cwg_scale #(.IN_W(XW)) u_scale (
      .v(src[ln]), .g($signed(gain)), .y(scaled[ln])
    );
  end

  assign spp_eff = (spp == '0) ? SPP_W'(1) : spp;
  assign is_last = (cnt_q >= spp_eff - SPP_W'(1));
  assign m_valid = (st_q == ST_HOLD) && en;
  assign m_last  = m_valid && is_last;
  assign m_data  = smp_q;
  assign accept  = m_valid && m_ready;
  assign start   = en && ((st_q == ST_OFF) || accept);
  assign cap     = (st_q == ST_CALC) && ((wave != WV_TONE) || !cbusy);

  always_comb begin
    phase_d = phase_q;
    if (phasor_wr)                         phase_d = '0;
    else if (accept && (wave == WV_TONE))  phase_d = phase_q + step;

    lfsr_d = lfsr_q;
    if (accept && (wave == WV_RAND))
      lfsr_d = {lfsr_q[NW-2:0], lfsr_q[31] ^ lfsr_q[21] ^ lfsr_q[1] ^ lfsr_q[0]};

    cnt_d = cnt_q;
    if (!en)         cnt_d = '0;
    else if (accept) cnt_d = is_last ? '0 : cnt_q + SPP_W'(1);

    smp_d = cap ? {scaled[0], scaled[1]} : smp_q;

    st_d = st_q;
    if (!en) st_d = ST_OFF;
    else begin
      case (st_q)
        ST_OFF:  st_d = ST_CALC;
        ST_CALC: if (cap) st_d = ST_HOLD;
        default: if (accept) st_d = ST_CALC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      lfsr_q  <= NW'(1);
      cnt_q   <= '0;
      smp_q   <= '0;
      st_q    <= ST_OFF;
    end else begin
      phase_q <= phase_d;
      lfsr_q  <= lfsr_d;
      cnt_q   <= cnt_d;
      smp_q   <= smp_d;
      st_q    <= st_d;
    end
  end
endmodule

// File: rtl/cwg_chk.sv
module cwg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [2:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        cfg_err,
  input logic        m_valid,
  input logic        m_ready,
  input logic [31:0] m_data,
  input logic        m_last,
  input logic        en
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !(cfg_we && cfg_addr == 3'd0))
      |=> (m_valid && $stable(m_data) && $stable(m_last))); // R10

  AST_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd0 && !cfg_wdata[0]) |=> !m_valid); // R9

  AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> en); // R9

  AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd7) |=> cfg_err); // R2

  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == 3'd7) |=> !cfg_err); // R2
endmodule

bind cplx_wavegen cwg_chk u_chk (
  .clk(clk), .rst_n(rst_ni), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_last(m_last), .en(en)
);

// File: tb/cplx_wavegen_tb.sv
module cplx_wavegen_tb;
  localparam time CLK_P = 8ns;
  localparam real PI = 3.14159265358979;

  // {fixed value, gain, expected word}
  localparam logic [79:0] VEC [0:4] = '{
    80'h4000C000_7FFF_4000C001,
    80'h7FFF8000_4000_4000C000,
    80'h80008000_8000_7FFF7FFF,
    80'h0100FF00_C000_FF800080,
    80'h12340000_0000_00000000
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        cfg_err;
  logic        m_valid;
  logic        m_ready;
  logic [31:0] m_data;
  logic        m_last;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  cplx_wavegen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic take(output logic [31:0] d, output logic l);
    int guard = 0;
    while (!m_valid && guard < 200) begin @(negedge clk); guard++; end
    if (!m_valid) chk(1'b0, "R10 sample never valid", 32'd0, 32'd1);
    d = m_data; l = m_last;
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  function automatic logic [15:0] sc(input logic signed [15:0] v, input logic signed [15:0] g);
    longint p = (longint'(v) * longint'(g) + 64'sd16384) >>> 15;
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return p[15:0];
  endfunction

  function automatic logic [31:0] nstep(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic tone_chk(input string tag, input logic [31:0] d, input real ei, input real eq);
    int ai = $signed(d[31:16]);
    int aq = $signed(d[15:0]);
    int xi = $rtoi(ei + (ei >= 0.0 ? 0.5 : -0.5));
    int xq = $rtoi(eq + (eq >= 0.0 ? 0.5 : -0.5));
    chk((ai - xi <= 64) && (xi - ai <= 64) && (aq - xq <= 64) && (xq - aq <= 64),
        tag, d, {xi[15:0], xq[15:0]});
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, d0;
    logic        l;
    logic [31:0] nm;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; m_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk(!m_valid, "R1 valid low in reset", {31'd0, m_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!m_valid && !cfg_err, "R1 idle after reset", {30'd0, m_valid, cfg_err}, 32'd0);

    // R1: defaults give a zero fixed-value sample, no end flag
    wr(3'd0, 32'd1);
    take(d, l);
    chk(d == 32'd0 && !l, "R1 default sample", d, 32'd0);
    wr(3'd0, 32'd0);

    // R4 / R5: vector table
    for (int i = 0; i < 5; i++) begin
      wr(3'd4, VEC[i][79:48]);
      wr(3'd3, {16'd0, VEC[i][47:32]});
      wr(3'd0, 32'd1);
      take(d, l);
      chk(d == VEC[i][31:0], $sformatf("R4 R5 vector %0d", i), d, VEC[i][31:0]);
      chk(sc(VEC[i][79:64], VEC[i][47:32]) == VEC[i][31:16], "R5 bench model", {16'd0, sc(VEC[i][79:64], VEC[i][47:32])}, {16'd0, VEC[i][31:16]});
      wr(3'd0, 32'd0);
    end

    // R3: code 3 ignored
    wr(3'd2, 32'd3);
    wr(3'd4, 32'h1000_2000);
    wr(3'd3, 32'h7FFF);
    wr(3'd0, 32'd1);
    take(d, l);
    chk(d == 32'h1000_2000, "R3 code 3 ignored", d, 32'h1000_2000);

    // R2: undefined offset
    wr(3'd7, 32'hFFFF_FFFF);
    chk(cfg_err, "R2 error flag set", {31'd0, cfg_err}, 32'd1);
    @(negedge clk);
    chk(!cfg_err, "R2 error flag one cycle", {31'd0, cfg_err}, 32'd0);
    take(d, l);
    chk(d == 32'h1000_2000, "R2 bad write no effect", d, 32'h1000_2000);

    // R11: packet length 3, then 0
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd3);
    wr(3'd0, 32'd1);
    for (int k = 0; k < 7; k++) begin
      take(d, l);
      chk(l == (k % 3 == 2), $sformatf("R11 last at sample %0d", k), {31'd0, l}, {31'd0, (k % 3 == 2)});
    end
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd1);
    for (int k = 0; k < 3; k++) begin
      take(d, l);
      chk(l, "R11 length 0 acts as 1", {31'd0, l}, 32'd1);
    end

    // R12: restart mid packet
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd4);
    wr(3'd0, 32'd1);
    take(d, l); take(d, l);
    wr(3'd0, 32'd0);
    wr(3'd0, 32'd1);
    for (int k = 0; k < 4; k++) begin
      take(d, l);
      chk(l == (k == 3), $sformatf("R12 fresh packet sample %0d", k), {31'd0, l}, {31'd0, (k == 3)});
    end

    // R9: disabled means no valid
    m_ready = 1'b1;
    wr(3'd0, 32'd0);
    for (int k = 0; k < 10; k++) begin
      if (m_valid) chk(1'b0, "R9 valid while disabled", 32'd1, 32'd0);
      @(negedge clk);
    end
    chk(!m_valid, "R9 valid low while disabled", {31'd0, m_valid}, 32'd0);
    m_ready = 1'b0;

    // R8 / R10: noise with stalls
    wr(3'd1, 32'd16);
    wr(3'd2, 32'd2);
    wr(3'd3, 32'h7FFF);
    wr(3'd0, 32'd1);
    nm = 32'd1;
    repeat (20) @(negedge clk);
    d0 = m_data;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!m_valid || m_data != d0) chk(1'b0, "R10 held under stall", m_data, d0);
    end
    chk(m_valid && m_data == d0, "R10 stall stable", m_data, d0);
    for (int k = 0; k < 6; k++) begin
      take(d, l);
      chk(d == {sc(nm[31:16], 16'h7FFF), sc(nm[15:0], 16'h7FFF)}, $sformatf("R8 noise sample %0d", k),
          d, {sc(nm[31:16], 16'h7FFF), sc(nm[15:0], 16'h7FFF)});
      nm = nstep(nm);
    end

    // R6: tone, step pi/4, magnitude 16384
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd1);
    wr(3'd6, 32'h36F7_0000);
    wr(3'd5, 32'd2048);
    wr(3'd0, 32'd1);
    for (int k = 0; k < 16; k++) begin
      take(d, l);
      tone_chk($sformatf("R6 tone sample %0d", k), d,
               16384.0 * $cos(k * PI / 4.0), 16384.0 * $sin(k * PI / 4.0));
    end
    take(d, l); take(d, l);

    // R7: phasor write restarts angle
    wr(3'd0, 32'd0);
    wr(3'd6, 32'h0000_36F7);
    wr(3'd0, 32'd1);
    take(d, l);
    tone_chk("R7 angle zero after phasor write", d, 0.0, 16384.0);
    take(d, l);
    tone_chk("R7 next step", d, -11585.2, 11585.2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule